// File: doc/BRIEF.md
# Status register and write-enable gate

This block is the write-protection and status core of a serial non-volatile memory. It keeps a write-enable latch, a write-in-progress flag and a two-bit block-protect code. It judges every modifying command that the serial front end decodes and runs a self-timed write cycle for each command it accepts. The front end sends one-cycle strobes: enable writes, disable writes, write the status register (with its data byte), and start a memory write (with its address). The block answers each status-write or memory-write strobe in the same cycle with an accept or a reject pulse.

An accepted command starts a fixed-length busy interval, and the memory back end commits its data during that interval. The status byte presented for reads always shows the live latch and busy flag. While a status write runs, the block-protect code still shows its old value, and the new code appears only when the cycle ends. The protect bits are held in ordinary flops that reset to 00.

Top module: `stat_guard`

## Requirements
- R1: `status_byte` is {4'b1111, BP1, BP0, WEL, WIP}: bits 7..4 read 1, bits 3..2 are the protect code, bit 1 is the write-enable latch and bit 0 is the in-progress flag.
- R2: A `cmd_wren` strobe sets WEL at the next clock edge. A `cmd_wrdi` strobe clears it at the next clock edge.
- R3: While `wp_n` is 0, WEL is cleared at the next clock edge. In that same cycle, any status-write or memory-write strobe is rejected.
- R4: A `cmd_wrsr` strobe is accepted (`wrsr_ok`=1) only when WEL=1, no cycle is running and `wp_n`=1. In every other case `wrsr_rej` pulses in that same cycle instead.
- R5: After an accepted command, `busy` and WIP are 1 from the next clock edge for exactly WR_CYCLES cycles, and then return to 0.
- R6: WEL is cleared at the edge where a cycle ends. When a clear event (`wp_n` low, cycle end or `cmd_wrdi`) coincides with `cmd_wren`, WEL ends up 0.
- R7: An accepted status write loads `wrsr_data[3:2]` into {BP1,BP0} at the edge where its cycle ends. Bits 7..4 and 1..0 of the data have no effect. The old code stays visible while the cycle runs.
- R8: The protect code selects a protected region at the top of the address space: 00 protects nothing, 01 the upper quarter (two address MSBs = 11), 10 the upper half (address MSB = 1), and 11 every address.
- R9: A `cmd_write` strobe is accepted (`write_ok`) under the conditions of R4, and only if its address lies outside the protected region. Otherwise `write_rej` pulses in that same cycle.
- R10: Reset (`rst_n`=0, asynchronous) clears WEL, WIP and `busy`, and sets the protect code to 00. `status_byte` then reads 8'hF0.
- R11: While a cycle runs, `cmd_wren` and `cmd_wrdi` still change WEL. The running cycle continues and ends on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cmd_wren | input | 1 | Enable-writes strobe |
| cmd_wrdi | input | 1 | Disable-writes strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Memory-write strobe |
| write_addr | input | ADDR_W | Address of the memory write |
| wp_n | input | 1 | Write-protect pin, active low |
| status_byte | output | 8 | Status byte for reads |
| wrsr_ok | output | 1 | Status write accepted |
| wrsr_rej | output | 1 | Status write rejected |
| write_ok | output | 1 | Memory write accepted |
| write_rej | output | 1 | Memory write rejected |
| busy | output | 1 | Self-timed write cycle running |

## Verification
The accept and reject verdicts are combinational, so they are due in the same cycle as their strobe. WEL and the start of `busy` are due one edge after the strobe. The new protect code is due at the edge where `busy` falls, WR_CYCLES edges after acceptance. The bench drives inputs just after the rising edge and compares every output on the falling edge against a behavioural model. The model first predicts the outputs from its current state and the inputs, then advances itself by one edge, so each prediction targets exactly the cycle in which the result should appear.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;
  typedef enum logic {
    CYC_MEM  = 1'b0,
    CYC_STAT = 1'b1
  } cyc_kind_t;

  localparam int unsigned STATUS_W = 8;
  localparam logic [3:0]  STATUS_TOP = 4'b1111;
endpackage

// File: rtl/sg_cycle_timer.sv
module sg_cycle_timer #(
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_nx = cnt_q;
    if (start)             cnt_nx = LOAD;
    else if (cnt_q != '0)  cnt_nx = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);
endmodule

// File: rtl/sg_region_guard.sv
module sg_region_guard #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned MSB = ADDR_W - 1;

  generate
    if (ADDR_W >= 2) begin : g_wide
      always_comb begin
        unique case (bp)
          2'b00:   hit = 1'b0;
          2'b01:   hit = addr[MSB] & addr[MSB-1];
          2'b10:   hit = addr[MSB];
          default: hit = 1'b1;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        unique case (bp)
          2'b00:   hit = 1'b0;
          2'b01:   hit = 1'b0;
          2'b10:   hit = addr[MSB];
          default: hit = 1'b1;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/stat_guard.sv
module stat_guard
  import stat_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wren,
  input  logic                cmd_wrdi,
  input  logic                cmd_wrsr,
  input  logic [7:0]          wrsr_data,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   write_addr,
  input  logic                wp_n,
  output logic [STATUS_W-1:0] status_byte,
  output logic                wrsr_ok,
  output logic                wrsr_rej,
  output logic                write_ok,
  output logic                write_rej,
  output logic                busy
);
  logic      wel_q, wel_nx;
  logic [1:0] bp_q, bp_nx, pend_q;
  cyc_kind_t kind_q;
  logic      start, done, hit, gate, wel_clr, bp_en;
  logic      unused_data;

  assign unused_data = ^{wrsr_data[7:4], wrsr_data[1:0]};

  sg_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  sg_region_guard #(.ADDR_W(ADDR_W)) u_region (
    .bp(bp_q), .addr(write_addr), .hit(hit)
  );

  // verdicts
  always_comb begin
    gate      = wel_q & ~busy & wp_n;
    wrsr_ok   = cmd_wrsr & gate;
    wrsr_rej  = cmd_wrsr & ~gate;
    write_ok  = cmd_write & gate & ~hit;
    write_rej = cmd_write & ~(gate & ~hit);
    start     = wrsr_ok | write_ok;
  end

  // next state
  always_comb begin
    wel_clr = ~wp_n | done | cmd_wrdi;
    wel_nx  = wel_q;
    if (wel_clr)       wel_nx = 1'b0;
    else if (cmd_wren) wel_nx = 1'b1;
    bp_en = done & (kind_q == CYC_STAT);
    bp_nx = bp_en ? pend_q : bp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      bp_q  <= 2'b00;
    end else begin
      wel_q <= wel_nx;
      if (bp_en) bp_q <= bp_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CYC_MEM;
      pend_q <= 2'b00;
    end else if (start) begin
      kind_q <= wrsr_ok ? CYC_STAT : CYC_MEM;
      pend_q <= wrsr_data[3:2];
    end
  end

  assign status_byte = {STATUS_TOP, bp_q, wel_q, busy};
endmodule

// File: rtl/stat_guard_chk.sv
module stat_guard_chk #(
  parameter int unsigned WR_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic [7:0] status_byte,
  input logic       wrsr_ok,
  input logic       write_ok,
  input logic       busy
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_ACCEPT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_ok || write_ok) |=> busy); // R5

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WR_CYCLES)); // R5

  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wrsr_ok || write_ok)); // R4

  AST_WP_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !status_byte[1]); // R3

  AST_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status_byte[1]); // R6

  AST_BP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status_byte[3:2])); // R7
endmodule

bind stat_guard stat_guard_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .status_byte(status_byte),
  .wrsr_ok(wrsr_ok), .write_ok(write_ok), .busy(busy)
);

// File: tb/test_stat_guard.sv
module test_stat_guard;
  localparam int ADDR_W = 9;
  localparam int WR_CYCLES = 16;
  localparam int SPACE = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
  logic [7:0] wrsr_data = '0;
  logic [ADDR_W-1:0] write_addr = '0;
  logic wp_n = 1'b1;
  logic [7:0] status_byte;
  logic wrsr_ok, wrsr_rej, write_ok, write_rej, busy;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_wel = 0, m_bp = 0, m_left = 0, m_kind_st = 0, m_pend = 0;

  always #10 clk = ~clk;

  stat_guard #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) i_stat_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
    .write_addr(write_addr), .wp_n(wp_n), .status_byte(status_byte),
    .wrsr_ok(wrsr_ok), .wrsr_rej(wrsr_rej), .write_ok(write_ok),
    .write_rej(write_rej), .busy(busy)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int in_region(input int bp, input int addr);
    case (bp)
      0: return 0;
      1: return (addr >= (SPACE * 3) / 4) ? 1 : 0;
      2: return (addr >= SPACE / 2) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_bp = 0; m_left = 0; m_kind_st = 0; m_pend = 0;
      chk(status_byte == 8'hF0, "R10 status in reset", status_byte, 8'hF0);
      chk(busy == 1'b0, "R10 busy in reset", busy, 0);
    end else begin
      int exp_stat, ok_sr, ok_wr, done;
      exp_stat = 8'hF0 | (m_bp << 2) | (m_wel << 1) | ((m_left > 0) ? 1 : 0);
      ok_sr = (cmd_wrsr && m_wel == 1 && m_left == 0 && wp_n) ? 1 : 0;
      ok_wr = (cmd_write && m_wel == 1 && m_left == 0 && wp_n &&
               in_region(m_bp, int'(write_addr)) == 0) ? 1 : 0;
      chk(status_byte[7:4] == 4'hF, "R1 status top nibble", status_byte[7:4], 4'hF);
      chk(int'(status_byte[1]) == m_wel, "R2/R3/R6/R11 WEL", status_byte[1], m_wel);
      chk(int'(status_byte[0]) == ((m_left > 0) ? 1 : 0), "R5 WIP", status_byte[0], (m_left > 0));
      chk(int'(busy) == ((m_left > 0) ? 1 : 0), "R5 busy", busy, (m_left > 0));
      chk(int'(status_byte[3:2]) == m_bp, "R7/R10 protect code", status_byte[3:2], m_bp);
      chk(int'(status_byte) == exp_stat, "R1 status byte", status_byte, exp_stat);
      chk(int'(wrsr_ok) == ok_sr, "R4 wrsr_ok", wrsr_ok, ok_sr);
      chk(int'(wrsr_rej) == (cmd_wrsr && !ok_sr), "R4/R3 wrsr_rej", wrsr_rej, (cmd_wrsr && !ok_sr));
      chk(int'(write_ok) == ok_wr, "R9/R8 write_ok", write_ok, ok_wr);
      chk(int'(write_rej) == (cmd_write && !ok_wr), "R9/R8 write_rej", write_rej, (cmd_write && !ok_wr));
      // advance model by one edge
      done = (m_left == 1) ? 1 : 0;
      if (m_left > 0) m_left = m_left - 1;
      if (done && m_kind_st) m_bp = m_pend;
      if (!wp_n || done || cmd_wrdi) m_wel = 0;
      else if (cmd_wren) m_wel = 1;
      if (ok_sr || ok_wr) begin
        m_left = WR_CYCLES;
        m_kind_st = ok_sr;
        m_pend = (int'(wrsr_data) >> 2) & 3;
      end
    end
  end

  task automatic step(input bit wren, input bit wrdi, input bit wrsr,
                      input logic [7:0] d, input bit wr, input int a);
    @(posedge clk); #1;
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; wrsr_data = d;
    cmd_write = wr; write_addr = ADDR_W'(a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    step(0, 0, 1, 8'hF4, 0, 0);          // R4 no WEL -> reject
    step(1, 0, 0, 8'h00, 0, 0);          // R2 set
    step(0, 0, 1, 8'hF4, 0, 0);          // R4 accept, R7 code 01
    idle(WR_CYCLES + 2);                 // R5 R6 R7
    step(0, 0, 0, 8'h00, 1, 'h1F0);      // R9 no WEL
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h00, 1, 'h1C0);      // R8 upper quarter protected
    step(0, 0, 0, 8'h00, 1, 'h100);      // R8 accept outside region
    step(1, 0, 0, 8'h00, 0, 0);          // R11 WEL set while busy
    step(0, 0, 1, 8'h00, 0, 0);          // R4 busy -> reject
    step(0, 1, 0, 8'h00, 0, 0);          // R11 WRDI while busy
    idle(WR_CYCLES);
    step(1, 0, 0, 8'h00, 0, 0);
    #2 wp_n = 1'b0;                      // R3
    step(0, 0, 1, 8'h0C, 0, 0);
    step(0, 0, 0, 8'h00, 1, 'h000);
    step(1, 0, 0, 8'h00, 0, 0);          // R6 wren vs wp low
    step(0, 0, 0, 8'h00, 0, 0);
    #2 wp_n = 1'b1;
    step(1, 1, 0, 8'h00, 0, 0);          // R6 wren and wrdi together
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 1, 8'h0C, 0, 0);          // code 11
    idle(WR_CYCLES + 2);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h00, 1, 'h000);      // R8 whole array protected
    step(0, 0, 1, 8'hF3 ^ 8'h07, 0, 0);  // data F4 -> code 01; R7 ignores others
    idle(WR_CYCLES + 2);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 1, 8'hFB, 0, 0);          // code 10
    idle(WR_CYCLES + 2);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h00, 1, 'h0FF);      // R8 lower half allowed
    idle(WR_CYCLES + 2);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h00, 1, 'h100);      // R8 upper half rejected
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 1, 8'h00, 0, 0);
    idle(5);
    #2 rst_n = 1'b0;                     // R10 reset mid-cycle
    idle(2);
    #2 rst_n = 1'b1;
    idle(4);
    finish_run();
  end
endmodule